// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Identifier Acknowledge

This block gathers a parameterised number of level-sensitive interrupt inputs and drives one interrupt request line towards a single processor. A source reaches the processor only when three things are true: its input is high, it has been switched on in the global enable set, and it is unmasked in the processor's own mask set. The request line is the registered OR of all sources that meet these conditions.

Software never writes bitmaps. To change one source's enable bit or mask bit, it writes that source's number to a dedicated set or clear register. To find out what to service, it reads an acknowledge register. That register returns the number of the lowest-numbered eligible source, or 1023 when nothing is eligible. Reading it clears nothing. Software normally masks a source while servicing it and unmasks it afterwards.

The register port is a 32-bit bus with single-cycle access. A bank select bit picks between two register banks: the global bank and the processor bank. Read data appears on the clock edge after the access.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every source is disabled and masked, `cpu_irq` is low and `bus_rdata` is zero. This holds whatever the inputs are.
- R2: A read of global-bank offset 0x00 returns the parameter NUM_SRC in bits [11:2], with every other bit zero, on the edge after the read.
- R3: A write of value k < NUM_SRC to global-bank offset 0x30 sets the enable bit of source k and no other bit.
- R4: A write of value k < NUM_SRC to global-bank offset 0x34 clears the enable bit of source k and no other bit.
- R5: A write of k < NUM_SRC to processor-bank offset 0x48 masks source k, and a write to offset 0x4C unmasks it. No other source changes.
- R6: A write to any of the four set or clear registers whose full 32-bit value is NUM_SRC or more changes nothing. This holds even when the low bits of that value name a valid source.
- R7: A read of processor-bank offset 0x44 returns, in bits [9:0], the lowest-numbered source whose input is high, whose enable bit is set and which is unmasked. It returns 1023 when no source qualifies. Bits [31:10] read as zero.
- R8: Reading offset 0x44 changes no state. Repeated reads with unchanged inputs return the same identifier.
- R9: `cpu_irq` is high on the edge after a cycle in which at least one source qualifies, and low otherwise. It is high exactly when an acknowledge read in the same cycle would return something other than 1023.
- R10: Sources are level-sensitive. Once a source's input drops, that source no longer appears in the acknowledge register or on `cpu_irq`, and no write is needed to retire it.
- R11: An offset is decoded only in its own bank. A write to 0x30 or 0x34 in the processor bank, or to 0x48 or 0x4C in the global bank, changes nothing. Reads of unmapped offsets, and the cycle after any write, give zero on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_bank | input | 1 | 0 = global bank, 1 = processor bank |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_wdata | input | 32 | Write data (source number for set/clear registers) |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq_src | input | NUM_SRC | Level-sensitive interrupt inputs |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the controller with NUM_SRC = 40. This count is not a power of two, so the control register value is easy to tell apart from a power of two. It also means that indices 40 to 63 still fit the 6-bit index field but must be rejected. A value such as 66 aliases to source 2 in its low bits, which shows that range checking looks at the whole write word and not a truncated index. Source 39 exercises the top boundary of the lowest-first search. A long random phase mixes level changes, set/clear traffic and acknowledge reads against the behavioural model on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ID_W    = 10;
  localparam int ID_NONE = 1023;

  // Byte offsets, global bank
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_EN_SET = 'h30;
  localparam int OFS_EN_CLR = 'h34;
  // Byte offsets, processor bank
  localparam int OFS_ACK    = 'h44;
  localparam int OFS_MK_SET = 'h48;
  localparam int OFS_MK_CLR = 'h4C;

  typedef enum logic {
    BANK_GLOBAL = 1'b0,
    BANK_CPU    = 1'b1
  } bank_e;
endpackage

// File: rtl/irqc_bitreg.sv
// One bit per source, changed one bit at a time by index strobes.
module irqc_bitreg #(
  parameter int N       = 64,
  parameter int IDX_W   = 6,
  parameter bit RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     bits
);
  logic [N-1:0] bits_nxt;

  always_comb begin
    bits_nxt = bits;
    for (int i = 0; i < N; i++) begin
      if (idx == IDX_W'(i)) begin
        if (set_stb)      bits_nxt[i] = 1'b1;
        else if (clr_stb) bits_nxt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bits <= {N{RST_VAL}};
    else     bits <= bits_nxt;
  end
endmodule

// File: rtl/irqc_pick.sv
// Lowest-numbered set bit wins; ID_NONE when the vector is empty.
module irqc_pick
  import irqc_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N-1:0]    vec,
  output logic            hit,
  output logic [ID_W-1:0] id
);
  always_comb begin
    hit = 1'b0;
    id  = ID_W'(ID_NONE);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic               bus_bank,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               cpu_irq
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [31:0] CTRL_VAL = {20'd0, 10'(NUM_SRC), 2'b00};

  logic wr, rd, in_glb, in_cpu, idx_ok;
  logic en_set, en_clr, mk_set, mk_clr;
  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] en_bits, mk_bits, elig;
  logic               any_hit;
  logic [ID_W-1:0]    win_id;
  logic [31:0]        rd_val;

  assign wr     = bus_en & bus_we;
  assign rd     = bus_en & ~bus_we;
  assign in_glb = (bank_e'(bus_bank) == BANK_GLOBAL);
  assign in_cpu = (bank_e'(bus_bank) == BANK_CPU);
  assign idx_ok = (bus_wdata < 32'(NUM_SRC));
  assign idx    = bus_wdata[IDX_W-1:0];

  assign en_set = wr & idx_ok & in_glb & (bus_addr == ADDR_W'(OFS_EN_SET));
  assign en_clr = wr & idx_ok & in_glb & (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign mk_set = wr & idx_ok & in_cpu & (bus_addr == ADDR_W'(OFS_MK_SET));
  assign mk_clr = wr & idx_ok & in_cpu & (bus_addr == ADDR_W'(OFS_MK_CLR));

  irqc_bitreg #(.N(NUM_SRC), .IDX_W(IDX_W), .RST_VAL(1'b0)) u_enable (
    .clk(clk), .rst(rst), .set_stb(en_set), .clr_stb(en_clr),
    .idx(idx), .bits(en_bits)
  );

  irqc_bitreg #(.N(NUM_SRC), .IDX_W(IDX_W), .RST_VAL(1'b1)) u_mask (
    .clk(clk), .rst(rst), .set_stb(mk_set), .clr_stb(mk_clr),
    .idx(idx), .bits(mk_bits)
  );

  assign elig = irq_src & en_bits & ~mk_bits;

  irqc_pick #(.N(NUM_SRC)) u_pick (
    .vec(elig), .hit(any_hit), .id(win_id)
  );

  always_comb begin
    rd_val = '0;
    if (in_glb && bus_addr == ADDR_W'(OFS_CTRL))
      rd_val = CTRL_VAL;
    else if (in_cpu && bus_addr == ADDR_W'(OFS_ACK))
      rd_val = {22'd0, win_id};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      bus_rdata <= rd ? rd_val : 32'd0;
      cpu_irq   <= any_hit;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_en,
  input logic               bus_we,
  input logic               bus_bank,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic [NUM_SRC-1:0] irq_src,
  input logic               cpu_irq
);
  logic ack_rd, ctl_rd;
  assign ack_rd = bus_en && !bus_we && bus_bank && (bus_addr == ADDR_W'(OFS_ACK));
  assign ctl_rd = bus_en && !bus_we && !bus_bank && (bus_addr == ADDR_W'(OFS_CTRL));

  AST_CTRL_COUNT: assert property (@(posedge clk) disable iff (rst)
    ctl_rd |=> bus_rdata == {20'd0, 10'(NUM_SRC), 2'b00}); // R2

  AST_ACK_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> bus_rdata[31:10] == 22'd0); // R7

  AST_ACK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> (32'(bus_rdata[9:0]) < 32'(NUM_SRC) || bus_rdata[9:0] == 10'(ID_NONE))); // R7

  AST_ACK_MATCHES_LINE: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> ((bus_rdata[9:0] == 10'(ID_NONE)) == !cpu_irq)); // R9

  AST_LINE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> $past(|irq_src)); // R10

  AST_WRITE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we) |=> bus_rdata == 32'd0); // R11
endmodule

bind lvl_irq_ctrl irqc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_bank(bus_bank),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_src(irq_src), .cpu_irq(cpu_irq)
);

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 40;
  localparam int AW   = 8;
  localparam int NONE = 1023;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0, bus_bank = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] irq_src = '0;
  logic cpu_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_ctrl #(.NUM_SRC(NSRC), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_bank(bus_bank),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .cpu_irq(cpu_irq)
  );

  // Behavioural reference: per-source enable/mask flags, updated per clock.
  bit m_en [NSRC];
  bit m_mk [NSRC];
  bit exp_irq = 0;
  logic [31:0] exp_rdata = '0;
  bit model_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_en[i]) begin m_en[i] = 0; m_mk[i] = 1; end
      exp_irq = 0;
      exp_rdata = 0;
    end else begin
      int low;
      low = NONE;
      for (int i = NSRC - 1; i >= 0; i--)
        if (irq_src[i] && m_en[i] && !m_mk[i]) low = i;
      exp_irq = (low != NONE);
      exp_rdata = 0;
      if (bus_en && !bus_we) begin
        if (!bus_bank && bus_addr == 8'h00) exp_rdata = NSRC * 4;
        else if (bus_bank && bus_addr == 8'h44) exp_rdata = low;
      end
      if (bus_en && bus_we && bus_wdata < NSRC) begin
        int k;
        k = int'(bus_wdata);
        if (!bus_bank && bus_addr == 8'h30) m_en[k] = 1;
        if (!bus_bank && bus_addr == 8'h34) m_en[k] = 0;
        if (bus_bank && bus_addr == 8'h48) m_mk[k] = 1;
        if (bus_bank && bus_addr == 8'h4C) m_mk[k] = 0;
      end
    end
    model_live = 1;
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (model_live && !finished) begin
      checks += 2;
      if (cpu_irq !== exp_irq) begin
        errors++;
        $display("FAIL %s cpu_irq actual %0b expected %0b at %0t", phase, cpu_irq, exp_irq, $time);
      end
      if (bus_rdata !== exp_rdata) begin
        errors++;
        $display("FAIL %s bus_rdata actual %0d expected %0d at %0t", phase, bus_rdata, exp_rdata, $time);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit bank, input int addr, input int val);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_bank = bank; bus_addr = AW'(addr); bus_wdata = 32'(val);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input bit bank, input int addr, output logic [31:0] val);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_bank = bank; bus_addr = AW'(addr);
    @(negedge clk);
    val = bus_rdata;
    bus_en = 0;
  endtask

  task automatic ack_is(input string req, input int exp);
    logic [31:0] v;
    rd(1, 'h44, v);
    check(req, v, 32'(exp));
  endtask

  initial begin
    logic [31:0] v;
    irq_src = '1;
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1 cpu_irq in reset", 32'(cpu_irq), 0);
    check("R1 rdata in reset", bus_rdata, 0);
    rst = 0;
    @(negedge clk);
    check("R1 cpu_irq after reset", 32'(cpu_irq), 0);
    ack_is("R1 nothing enabled", NONE);

    phase = "R2";
    rd(0, 'h00, v);
    check("R2 control count", v, 32'(NSRC * 4));

    phase = "R3";
    wr(0, 'h30, 5);
    ack_is("R3 enabled but masked", NONE);
    phase = "R5";
    wr(1, 'h4C, 5);
    ack_is("R5 unmasked source 5", 5);
    @(negedge clk);
    check("R9 line high", 32'(cpu_irq), 1);

    phase = "R7";
    wr(0, 'h30, 3);
    ack_is("R7 3 enabled but masked", 5);
    wr(1, 'h4C, 3);
    ack_is("R7 lowest wins", 3);
    phase = "R8";
    ack_is("R8 repeat read 1", 3);
    ack_is("R8 repeat read 2", 3);

    phase = "R5";
    wr(1, 'h48, 3);
    ack_is("R5 mask 3 hides it", 5);
    phase = "R4";
    wr(0, 'h34, 5);
    ack_is("R4 disable 5", NONE);
    @(negedge clk);
    check("R9 line low", 32'(cpu_irq), 0);

    phase = "R10";
    wr(0, 'h30, 5);
    ack_is("R10 re-enabled", 5);
    irq_src[5] = 0;
    @(negedge clk);
    ack_is("R10 level dropped", NONE);
    @(negedge clk);
    check("R10 line after drop", 32'(cpu_irq), 0);

    phase = "R6";
    wr(1, 'h4C, 2);
    wr(0, 'h30, 66);
    wr(0, 'h30, NSRC);
    wr(0, 'h30, 63);
    ack_is("R6 aliasing index ignored", NONE);
    wr(0, 'h30, 2);
    ack_is("R6 real index works", 2);
    wr(1, 'h48, 66);
    ack_is("R6 out-of-range mask ignored", 2);

    phase = "R11";
    wr(1, 'h34, 2);
    ack_is("R11 clear-enable in wrong bank", 2);
    wr(0, 'h48, 2);
    ack_is("R11 set-mask in wrong bank", 2);
    wr(1, 'h30, 7);
    wr(1, 'h4C, 7);
    ack_is("R11 stray enable gave nothing", 2);
    rd(0, 'h44, v);
    check("R11 ack offset in global bank", v, 0);
    rd(1, 'h00, v);
    check("R11 control offset in processor bank", v, 0);

    phase = "R7";
    wr(0, 'h34, 2);
    wr(0, 'h30, NSRC - 1);
    wr(1, 'h4C, NSRC - 1);
    ack_is("R7 top source", NSRC - 1);

    phase = "R9";
    for (int n = 0; n < 3000; n++) begin
      int op;
      int offs [4] = '{'h30, 'h34, 'h48, 'h4C};
      if ((n % 7) == 0) irq_src = {$urandom, $urandom};
      op = $urandom_range(0, 5);
      if (op < 2) begin
        int sel;
        sel = $urandom_range(0, 3);
        wr(sel >= 2, offs[sel], $urandom_range(0, 45));
      end else if (op < 5) begin
        rd(1, 'h44, v);
      end else begin
        @(negedge clk);
      end
    end

    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired in phase %s actual running expected done", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule